// File: doc/BRIEF.md
# Three-Port Programmable Parallel Interface

This block lets a processor drive three 8-bit parallel ports, called A, B and C, through a small register window. The processor side is a synchronous strobe bus. It has an active-low select, active-low read and write strobes, a two-bit register address and 8-bit write and read data. Every access finishes in the cycle it is presented, so the bus has no back-pressure and needs no wait states. Each peripheral line has an input pin, an output value and its own output-enable, so a tristate pad can be built around it.

One control address accepts two word formats. Bit 7 of the written word picks the format. One format sets the operating mode and the direction of each port group. The other forces a single port C line high or low. Port C is split into two 4-bit halves, and each half has its own direction.

Ports A and B can each be switched, independently of one another, into a strobed mode. In that mode a port moves data under a peripheral handshake. Fixed port C lines then carry the strobe or acknowledge, the buffer flag and the interrupt request for that port. This handshake is the only flow control on the peripheral side.

Top module: `pio_three_port`

## Requirements
- R1: The address selects the register: 0 is port A, 1 is port B, 2 is port C and 3 is control. Reading the control address returns bit 7 set and, in bits 6:0, the last mode word (0x9B after reset).
- R2: When cs_n is high, no register changes. rdata is 0 unless cs_n and rd_n are both low.
- R3: A control write with bit 7 = 1 is a mode word. Its fields are: bits 6:5 group A mode (01 = strobed, any other value = basic), bit 4 port A direction, bit 3 upper C direction, bit 2 group B mode (1 = strobed), bit 1 port B direction, bit 0 lower C direction. A direction bit of 1 means input. Every output line of a port has its oe set, and every input line has its oe clear.
- R4: Reset, and every mode word, set all output latches to 0 and clear every handshake flag and interrupt. Reset also makes every port an input.
- R5: A control write with bit 7 = 0 sets port C latch bit number (bits 3:1) to the value in bit 0. Bits 6:4 are ignored. The other port C bits and the configuration do not change.
- R6: In basic mode a written output value is held until the next write or mode word. A read of an input port returns the live pin values.
- R7: The upper and lower halves of port C take their directions independently. A port C read returns the driven value on output lines and the pin value on input lines.
- R8: In strobed input mode, a low strobe latches the port pins and raises the buffer-full and interrupt lines. A read of the port returns the latched byte and clears both lines. Port B uses PC2 for the strobe, PC1 for buffer-full and PC0 for the interrupt. Port A uses PC4, PC5 and PC3 for the same three signals.
- R9: In strobed output mode, a CPU write to the port drives the active-low buffer-full line low and clears the interrupt. A low acknowledge returns buffer-full high and raises the interrupt. Port B uses PC2 for the acknowledge, PC1 for buffer-full and PC0 for the interrupt. Port A uses PC6, PC7 and PC3 for the same three signals.
- R10: Ports A and B take their modes independently. Handshake lines override the port C half direction; every other port C line follows its half.
- R11: If a CPU write to a strobed output port and its acknowledge arrive in the same cycle, the write wins and buffer-full stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when idle |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C driven values, handshake outputs included |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench first targets the handshake corners. In one test a strobed input byte changes after its strobe ends; a design that read the live pins there would return the wrong byte. In another test a write arrives in the same cycle as an acknowledge; a design with the wrong priority would raise buffer-full and lose the pending byte. The single-bit word carries junk in its ignored bits; a design that decoded those bits would set the wrong line or rewrite the configuration. The bench also issues strobes with chip select high, and it loads data and then writes a new mode word. A design that got these wrong would let writes leak through or would leave stale data driving a pin that had just become an output.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PW = 8;
  localparam int HW = PW / 2;
  localparam int IW = $clog2(PW);
  localparam int CW = PW - 1;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } pio_sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RST = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // Port C handshake line positions
  localparam int B_HS   = 2;
  localparam int B_FLAG = 1;
  localparam int B_INT  = 0;
  localparam int A_INT  = 3;
  localparam int A_STB  = 4;
  localparam int A_IBF  = 5;
  localparam int A_ACK  = 6;
  localparam int A_OBF  = 7;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [PW-1:0] wdata,
  output pio_cfg_t      cfg,
  output logic          mode_wr,
  output logic          bit_we,
  output logic [IW-1:0] bit_idx,
  output logic          bit_val
);
  assign mode_wr = ctl_we & wdata[PW-1];
  assign bit_we  = ctl_we & ~wdata[PW-1];
  assign bit_idx = wdata[IW:1];
  assign bit_val = wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg <= CFG_RST;
    else if (mode_wr) cfg <= pio_cfg_t'(wdata[CW-1:0]);
  end
endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         strobed,
  input  logic         dir_in,
  input  logic         wr_hit,
  input  logic         rd_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         hs_n,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rd_val,
  output logic         full,
  output logic         intr
);
  logic [W-1:0] in_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      out_q <= '0;
      in_q  <= '0;
      full  <= 1'b0;
      intr  <= 1'b0;
    end else begin
      if (wr_hit) out_q <= wdata;
      if (strobed && dir_in) begin
        if (!hs_n) begin
          in_q <= pin_in;
          full <= 1'b1;
          intr <= 1'b1;
        end else if (rd_hit) begin
          full <= 1'b0;
          intr <= 1'b0;
        end
      end else if (strobed) begin
        if (wr_hit) begin
          full <= 1'b1;
          intr <= 1'b0;
        end else if (!hs_n) begin
          full <= 1'b0;
          intr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!dir_in)      rd_val = out_q;
    else if (strobed) rd_val = in_q;
    else              rd_val = pin_in;
  end
endmodule

// File: rtl/pio_portc.sv
module pio_portc
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  pio_cfg_t      cfg,
  input  logic          mode_wr,
  input  logic          data_we,
  input  logic [PW-1:0] wdata,
  input  logic          bit_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic [PW-1:0] pc_in,
  input  logic          a_full,
  input  logic          a_intr,
  input  logic          b_full,
  input  logic          b_intr,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe,
  output logic [PW-1:0] rd_val,
  output logic          a_hs_n,
  output logic          b_hs_n
);
  logic [PW-1:0] latch_q;
  logic          a_strobed;

  assign a_strobed = (cfg.a_mode == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) latch_q <= '0;
    else if (data_we)      latch_q <= wdata;
    else if (bit_we)       latch_q[bit_idx] <= bit_val;
  end

  always_comb begin
    pc_oe  = {{HW{~cfg.cu_in}}, {HW{~cfg.cl_in}}};
    pc_out = latch_q;
    if (cfg.b_mode) begin
      pc_oe[B_HS]    = 1'b0;
      pc_oe[B_FLAG]  = 1'b1;
      pc_oe[B_INT]   = 1'b1;
      pc_out[B_FLAG] = cfg.b_in ? b_full : ~b_full;
      pc_out[B_INT]  = b_intr;
    end
    if (a_strobed) begin
      pc_oe[A_INT]  = 1'b1;
      pc_out[A_INT] = a_intr;
      if (cfg.a_in) begin
        pc_oe[A_STB]  = 1'b0;
        pc_oe[A_IBF]  = 1'b1;
        pc_out[A_IBF] = a_full;
      end else begin
        pc_oe[A_ACK]  = 1'b0;
        pc_oe[A_OBF]  = 1'b1;
        pc_out[A_OBF] = ~a_full;
      end
    end
  end

  assign rd_val = (pc_oe & pc_out) | (~pc_oe & pc_in);
  assign a_hs_n = cfg.a_in ? pc_in[A_STB] : pc_in[A_ACK];
  assign b_hs_n = pc_in[B_HS];
endmodule

// File: rtl/pio_three_port.sv
module pio_three_port
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int NP = 2;

  pio_cfg_t         cfg;
  pio_sel_e         sel;
  logic             wr_en, rd_en, mode_wr, bit_we, bit_val;
  logic [IW-1:0]    bit_idx;
  logic [PW-1:0]    pc_rd;
  logic             a_hs_n, b_hs_n;
  logic [NP-1:0][PW-1:0] pin_v, out_v, rd_v;
  logic [NP-1:0]    strobed, dir_in, hs_n, wr_hit, rd_hit, full, intr;

  assign sel   = pio_sel_e'(addr);
  assign wr_en = ~cs_n & ~wr_n;
  assign rd_en = ~cs_n & ~rd_n & wr_n;

  pio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(wr_en && sel == SEL_CTL), .wdata(wdata),
    .cfg(cfg), .mode_wr(mode_wr), .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val)
  );

  assign pin_v   = {pb_in, pa_in};
  assign strobed = {cfg.b_mode, (cfg.a_mode == 2'b01)};
  assign dir_in  = {cfg.b_in, cfg.a_in};
  assign hs_n    = {b_hs_n, a_hs_n};

  for (genvar g = 0; g < NP; g++) begin : g_hs
    assign wr_hit[g] = wr_en && (addr == 2'(g));
    assign rd_hit[g] = rd_en && (addr == 2'(g));
    pio_hs_port #(.W(PW)) u_port (
      .clk(clk), .rst_n(rst_n), .clear(mode_wr), .strobed(strobed[g]),
      .dir_in(dir_in[g]), .wr_hit(wr_hit[g]), .rd_hit(rd_hit[g]),
      .wdata(wdata), .pin_in(pin_v[g]), .hs_n(hs_n[g]),
      .out_q(out_v[g]), .rd_val(rd_v[g]), .full(full[g]), .intr(intr[g])
    );
  end

  pio_portc u_portc (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .mode_wr(mode_wr),
    .data_we(wr_en && sel == SEL_C), .wdata(wdata),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val), .pc_in(pc_in),
    .a_full(full[0]), .a_intr(intr[0]), .b_full(full[1]), .b_intr(intr[1]),
    .pc_out(pc_out), .pc_oe(pc_oe), .rd_val(pc_rd), .a_hs_n(a_hs_n), .b_hs_n(b_hs_n)
  );

  assign pa_out = out_v[0];
  assign pb_out = out_v[1];
  assign pa_oe  = {PW{~cfg.a_in}};
  assign pb_oe  = {PW{~cfg.b_in}};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_A:   rdata = rd_v[0];
        SEL_B:   rdata = rd_v[1];
        SEL_C:   rdata = pc_rd;
        SEL_CTL: rdata = {1'b1, cfg};
      endcase
    end
  end
endmodule

// File: rtl/pio_three_port_chk.sv
module pio_three_port_chk
  import pio_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [1:0]    addr,
  input logic [PW-1:0] wdata,
  input logic [PW-1:0] rdata,
  input logic [PW-1:0] pa_out,
  input logic [PW-1:0] pa_oe,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] pb_oe,
  input logic [PW-1:0] pc_in,
  input logic [PW-1:0] pc_out,
  input logic [PW-1:0] pc_oe,
  input pio_cfg_t      cfg
);
  logic ctl_wr;
  assign ctl_wr = !cs_n && !wr_n && addr == 2'b11;

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) &&
              $stable(pb_oe) && $stable(pc_oe)));

  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> rdata == '0);

  a_r3_whole_port: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1)));

  a_r4_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[PW-1]) |=> (pa_out == '0 && pb_out == '0));

  a_r5_bit_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[PW-1]) |=> ($stable(pa_oe) && $stable(pb_oe) &&
                                  $stable(pc_oe) && $stable(pa_out)));

  a_r8_strobe_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.b_mode && cfg.b_in && !pc_in[B_HS] && cs_n) |=> pc_out[B_FLAG]);

  a_r9_write_drops_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'b01 && cfg.b_mode && !cfg.b_in) |=> !pc_out[B_FLAG]);
endmodule

bind pio_three_port pio_three_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out),
  .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .cfg(cfg)
);

// File: tb/test_pio_three_port.sv
module test_pio_three_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pio_three_port i_pio_three_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R4 reset pa_oe", pa_oe, 8'h00);
    chk("R4 reset pb_oe", pb_oe, 8'h00);
    chk("R4 reset pc_oe", pc_oe, 8'h00);
    chk("R4 reset pa_out", pa_out, 8'h00);
    bus_rd(2'b11, v);
    chk("R1 reset control read", v, 8'h9B);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    bus_wr(2'b11, 8'h80);
    bus_rd(2'b11, v);
    chk("R1 control readback", v, 8'h80);
    chk("R3 all out pa_oe", pa_oe, 8'hFF);
    chk("R3 all out pc_oe", pc_oe, 8'hFF);
    bus_wr(2'b00, 8'h5A);
    bus_wr(2'b01, 8'hC3);
    bus_wr(2'b10, 8'h3C);
    repeat (3) @(negedge clk);
    chk("R6 held pa_out", pa_out, 8'h5A);
    chk("R6 held pb_out", pb_out, 8'hC3);
    chk("R6 held pc_out", pc_out, 8'h3C);
    bus_rd(2'b00, v);
    chk("R1 read A latch", v, 8'h5A);
    bus_wr(2'b11, 8'h90);
    chk("R3 A input pa_oe", pa_oe, 8'h00);
    chk("R4 mode word clears pb_out", pb_out, 8'h00);
    pa_in = 8'h77;
    bus_rd(2'b00, v);
    chk("R6 live read 1", v, 8'h77);
    pa_in = 8'h11;
    bus_rd(2'b00, v);
    chk("R6 live read 2", v, 8'h11);
    bus_wr(2'b11, 8'hC0);
    chk("R3 A mode 10 is basic pc_oe", pc_oe, 8'hFF);
  endtask

  task automatic t_cs();
    logic [7:0] v;
    bus_wr(2'b11, 8'h90);
    bus_wr(2'b01, 8'h42);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'b01; wdata = 8'hEE;
    @(negedge clk);
    wr_n = 1'b1;
    chk("R2 deselected write ignored", pb_out, 8'h42);
    @(negedge clk);
    rd_n = 1'b0; addr = 2'b01;
    #1 chk("R2 deselected read zero", rdata, 8'h00);
    rd_n = 1'b1; cs_n = 1'b0;
    #1 chk("R2 no strobe read zero", rdata, 8'h00);
    cs_n = 1'b1;
    bus_rd(2'b01, v);
    chk("R2 selected read", v, 8'h42);
  endtask

  task automatic t_nibble();
    logic [7:0] v;
    bus_wr(2'b11, 8'h88);
    chk("R7 split pc_oe", pc_oe, 8'h0F);
    pc_in = 8'hA5;
    bus_wr(2'b10, 8'h0C);
    bus_rd(2'b10, v);
    chk("R7 mixed C read", v, 8'hAC);
    pc_in = 8'hFF;
  endtask

  task automatic t_bitset();
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h99);
    bus_wr(2'b10, 8'h00);
    bus_wr(2'b11, 8'h7D);
    chk("R5 set bit6 junk ignored", pc_out, 8'h40);
    bus_wr(2'b11, 8'h03);
    chk("R5 set bit1", pc_out, 8'h42);
    bus_wr(2'b11, 8'h0C);
    chk("R5 clear bit6", pc_out, 8'h02);
    chk("R5 config kept", pa_oe, 8'hFF);
    chk("R5 port A kept", pa_out, 8'h99);
  endtask

  task automatic t_strobe_in_b();
    logic [7:0] v;
    bus_wr(2'b11, 8'h86);
    chk("R10 handshake overrides pc_oe", pc_oe, 8'hFB);
    chk("R4 flags clear", pc_out & 8'h03, 8'h00);
    @(negedge clk);
    pb_in = 8'h3E; pc_in[2] = 1'b0;
    @(negedge clk);
    pc_in[2] = 1'b1; pb_in = 8'hFF;
    chk("R8 ibf and intr set", pc_out & 8'h03, 8'h03);
    bus_rd(2'b01, v);
    chk("R8 latched byte", v, 8'h3E);
    chk("R8 read clears ibf and intr", pc_out & 8'h03, 8'h00);
  endtask

  task automatic t_strobe_out_a();
    logic [7:0] v;
    bus_wr(2'b11, 8'hA2);
    chk("R10 A out handshake pc_oe", pc_oe, 8'hBF);
    chk("R10 B stays basic input", pb_oe, 8'h00);
    pb_in = 8'h5C;
    bus_rd(2'b01, v);
    chk("R10 B live read", v, 8'h5C);
    chk("R9 obf idle high intr low", pc_out & 8'h88, 8'h80);
    bus_wr(2'b00, 8'h81);
    chk("R9 write drops obf", pc_out & 8'h88, 8'h00);
    chk("R9 data driven", pa_out, 8'h81);
    @(negedge clk);
    pc_in[6] = 1'b0;
    @(negedge clk);
    pc_in[6] = 1'b1;
    chk("R9 ack raises obf and intr", pc_out & 8'h88, 8'h88);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'b00; wdata = 8'h24; pc_in[6] = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; pc_in[6] = 1'b1;
    chk("R11 write beats ack", pc_out & 8'h88, 8'h00);
    chk("R11 new data", pa_out, 8'h24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_cs();
    t_nibble();
    t_bitset();
    t_strobe_in_b();
    t_strobe_out_a();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule